// File: doc/BRIEF.md
# Character LCD Glyph Streaming Controller

This block drives a parallel character display over a write-only bus made of a register-select line, a read/write line, an 8-bit data bus and an enable strobe. After reset it sends a fixed list of four setup commands to the display on its own. Only then does it accept characters.

Each character is offered on a valid/ready handshake together with a line bit and a column number. The block first writes a cursor-placement command. It then streams the eight bytes of that character's glyph from an internal 2048 x 8 glyph memory. The start address of the glyph is the character code times eight. This address is loaded into an 11-bit address counter. A 3-bit row counter counts the eight bytes and stops both counters at its terminal count. A multiplexer chooses what drives the data bus: the command register while commands are sent, or the glyph memory output while glyph bytes are sent.

Every bus write occupies one slot of 80 system clocks. The enable strobe rises two clocks into the slot and stays high for 40 clocks. All strobe timing comes from counting system clocks only.

Top module: `lcd_glyph_streamer`

## Requirements
- R1: After reset is released the block writes four commands with register select low, in this order: 0x38, 0x0C, 0x06, 0x01. `in_ready` first goes high 320 clocks after the release.
- R2: `in_ready` is high only while the block is idle. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low for exactly 720 clocks (nine write slots).
- R3: A request that arrives while the block is busy is not lost. The block takes it as soon as it returns to idle, and the request does not disturb the character already being written.
- R4: The first write for a character has register select low and data equal to 0x80 OR (line << 6) OR column. The column is 6 bits wide and the line is 1 bit.
- R5: The next eight writes have register select high. Byte i (i = 0..7) is the glyph memory word at address code*8+i. Word a of the glyph memory holds (a >> 3) XOR ((a mod 8) << 5), truncated to 8 bits.
- R6: Each write is one enable pulse. The pulse is high for exactly 40 clocks, and the strobe stays low for at least 40 clocks between pulses.
- R7: Data and register select stay unchanged for at least 2 clocks before the enable strobe rises, for the whole high time, and for at least 2 clocks after it falls.
- R8: The read/write line is low at all times.
- R9: Character codes 0x00 and 0xFF read glyph addresses 0..7 and 2040..2047, the two ends of the glyph memory.
- R10: A reset in the middle of a character stops it at once. The strobe goes low, `in_ready` goes low, and the setup command list is sent again from its first entry.
- R11: After the eighth glyph byte both counters stop. No further enable pulse occurs while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A character request is present |
| in_ready | output | 1 | High when idle; the request is taken on valid and ready |
| in_code | input | 8 | Character code, used to select the glyph |
| in_line | input | 1 | Display line for the character |
| in_col | input | 6 | Display column for the character |
| lcd_rs | output | 1 | Register select: 0 for a command, 1 for glyph data |
| lcd_rw | output | 1 | Read/write select, held low |
| lcd_data | output | 8 | Display data bus |
| lcd_e | output | 1 | Enable strobe |

## Verification
Each display write is counted as done on the clock where the enable strobe rises. The bench records register select and data at that point. It samples only on falling clock edges, so every register has settled. The setup list must show up as four writes, with `in_ready` rising 320 clocks after reset release. A character must give nine writes, with `in_ready` back exactly 720 clocks after the edge that took the request. The bench counts these delays clock by clock from the accepting edge instead of waiting a loose amount of time. On every pulse a monitor also checks the 40-clock high time, the minimum low time, and the 2-clock setup and hold around the strobe.

// File: rtl/lcd_glyph_pkg.sv
package lcd_glyph_pkg;

    localparam int INIT_LEN = 4;
    localparam int INIT_IW  = $clog2(INIT_LEN);

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_POS   = 2'd2,
        ST_GLYPH = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e           st;
        logic [INIT_IW-1:0]   idx;
        logic [7:0]           cmd;
        logic                 rs;
    } seq_t;

    // display setup list: bus width/lines, display on, entry mode, clear
    function automatic logic [7:0] init_cmd(input logic [INIT_IW-1:0] i);
        logic [7:0] v;
        case (i)
            2'd0:    v = 8'h38;
            2'd1:    v = 8'h0C;
            2'd2:    v = 8'h06;
            default: v = 8'h01;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lcd_e_timer.sv
module lcd_e_timer #(
    parameter int E_HIGH = 40,
    parameter int E_LOW  = 40,
    parameter int SETUP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic slot_done_o,
    output logic e_o
);
    localparam int SLOT = E_HIGH + E_LOW;
    localparam int CW   = $clog2(SLOT);
    localparam logic [CW-1:0] LAST  = CW'(SLOT - 1);
    localparam logic [CW-1:0] E_ON  = CW'(SETUP);
    localparam logic [CW-1:0] E_OFF = CW'(SETUP + E_HIGH);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign slot_done_o = run_i && (cnt_q == LAST);
    assign e_o         = run_i && (cnt_q >= E_ON) && (cnt_q < E_OFF);

    // R7
    e_setup_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_o) |-> ($past(run_i) && $past(run_i, 2)));

    // R6
    e_clear_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done_o |=> !e_o);

endmodule

// File: rtl/lcd_glyph_addr.sv
module lcd_glyph_addr #(
    parameter int CODE_W = 8,
    parameter int ROWS   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_i,
    input  logic [CODE_W-1:0]                 code_i,
    input  logic                              step_i,
    output logic [CODE_W+$clog2(ROWS)-1:0]    addr_o,
    output logic [CODE_W+$clog2(ROWS)-1:0]    addr_next_o,
    output logic                              tc_o
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int ADDR_W = CODE_W + ROW_W;
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ROW_W-1:0]  row;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load_i) begin
            c_d.addr = {code_i, {ROW_W{1'b0}}};
            c_d.row  = '0;
        end else if (step_i) begin
            c_d.addr = c_q.addr + 1'b1;
            c_d.row  = c_q.row + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            c_q <= '0;
        else
            c_q <= c_d;
    end

    assign addr_o      = c_q.addr;
    assign addr_next_o = c_d.addr;
    assign tc_o        = (c_q.row == ROW_LAST);

    // R11
    no_step_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !tc_o);

    // R5
    row_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (c_q.row == '0) && (addr_o[ROW_W-1:0] == '0));

endmodule

// File: rtl/lcd_glyph_rom.sv
module lcd_glyph_rom #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] = DATA_W'(i >> ROW_W) ^ DATA_W'((i % (1 << ROW_W)) << (DATA_W - ROW_W));
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= mem_q[rd_addr_i];
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/lcd_glyph_streamer.sv
module lcd_glyph_streamer
    import lcd_glyph_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int ROWS   = 8,
    parameter int E_HIGH = 40,
    parameter int E_LOW  = 40,
    parameter int SETUP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_line,
    input  logic [5:0]        in_col,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic [7:0]        lcd_data,
    output logic              lcd_e
);
    localparam int DATA_W = 8;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int ADDR_W = CODE_W + ROW_W;
    localparam logic [INIT_IW-1:0] INIT_LAST = INIT_IW'(INIT_LEN - 1);
    localparam seq_t SEQ_RST = '{st: ST_INIT, idx: '0, cmd: init_cmd('0), rs: 1'b0};

    seq_t q_d, q_q;

    logic              slot_done, run, load, step, tc;
    logic [ADDR_W-1:0] addr, addr_next;
    logic [DATA_W-1:0] glyph_byte;

    lcd_e_timer #(.E_HIGH(E_HIGH), .E_LOW(E_LOW), .SETUP(SETUP)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .slot_done_o (slot_done),
        .e_o         (lcd_e)
    );

    lcd_glyph_addr #(.CODE_W(CODE_W), .ROWS(ROWS)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .code_i      (in_code),
        .step_i      (step),
        .addr_o      (addr),
        .addr_next_o (addr_next),
        .tc_o        (tc)
    );

    lcd_glyph_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_rom (
        .clk       (clk),
        .rd_addr_i (addr_next),
        .rd_data_o (glyph_byte)
    );

    always_comb begin
        q_d  = q_q;
        load = 1'b0;
        step = 1'b0;
        unique case (q_q.st)
            ST_INIT: begin
                if (slot_done) begin
                    if (q_q.idx == INIT_LAST) begin
                        q_d.st = ST_IDLE;
                    end else begin
                        q_d.idx = q_q.idx + 1'b1;
                        q_d.cmd = init_cmd(q_q.idx + 1'b1);
                    end
                end
            end
            ST_IDLE: begin
                if (in_valid) begin
                    q_d.st  = ST_POS;
                    q_d.cmd = {1'b1, in_line, in_col};
                    q_d.rs  = 1'b0;
                    load    = 1'b1;
                end
            end
            ST_POS: begin
                if (slot_done) begin
                    q_d.st = ST_GLYPH;
                    q_d.rs = 1'b1;
                end
            end
            ST_GLYPH: begin
                if (slot_done) begin
                    if (tc)
                        q_d.st = ST_IDLE;
                    else
                        step = 1'b1;
                end
            end
            default: q_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_q <= SEQ_RST;
        else
            q_q <= q_d;
    end

    assign run      = (q_q.st != ST_IDLE);
    assign in_ready = (q_q.st == ST_IDLE);
    assign lcd_rs   = q_q.rs;
    assign lcd_rw   = 1'b0;
    assign lcd_data = q_q.rs ? glyph_byte : q_q.cmd;

    // R7
    setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> ($past(lcd_data) == lcd_data) && ($past(lcd_data, 2) == lcd_data)
                         && ($past(lcd_rs) == lcd_rs));

    // R7
    high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    // R7
    hold_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |=> ($stable(lcd_data) && $stable(lcd_rs)));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R6
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !lcd_e);

endmodule

// File: tb/sim_lcd_glyph_streamer.sv
module sim_lcd_glyph_streamer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_code = '0;
    logic       in_line = 1'b0;
    logic [5:0] in_col = '0;
    logic       lcd_rs, lcd_rw, lcd_e;
    logic [7:0] lcd_data;

    always #10 clk = ~clk;

    lcd_glyph_streamer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .in_line(in_line), .in_col(in_col),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_data(lcd_data), .lcd_e(lcd_e)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] glyph_word(input int code, input int row);
        int a;
        a = code * 8 + row;
        return {1'b1, 8'((a >> 3) ^ ((a % 8) << 5))};
    endfunction

    // ---------------- bus monitor ----------------
    int         cyc = 0;
    always @(posedge clk) cyc++;

    logic       prev_e;
    logic [8:0] prev_word;
    int         hi_len, lo_len, last_chg, fall_cyc;
    logic [8:0] cap [0:511];
    int         wr_cnt = 0;
    bit         rw_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_e    = 1'b0;
            hi_len    = 0;
            lo_len    = 1000;
            last_chg  = cyc;
            fall_cyc  = -1000;
            prev_word = {lcd_rs, lcd_data};
        end else begin
            if (lcd_rw) rw_bad = 1;
            if ({lcd_rs, lcd_data} != prev_word) begin
                check(!lcd_e && (cyc - fall_cyc >= 2), "R7 change only 2+ clocks after E low",
                      cyc - fall_cyc, 2);
                last_chg = cyc;
            end
            if (lcd_e && !prev_e) begin
                check(cyc - last_chg >= 2, "R7 setup before E rise", cyc - last_chg, 2);
                check(lo_len >= 40, "R6 E low time", lo_len, 40);
                if (wr_cnt < 512) cap[wr_cnt] = {lcd_rs, lcd_data};
                wr_cnt++;
                hi_len = 1;
            end else if (lcd_e) begin
                hi_len++;
            end else if (prev_e) begin
                check(hi_len == 40, "R6 E high time", hi_len, 40);
                fall_cyc = cyc;
                lo_len   = 1;
            end else begin
                lo_len++;
            end
            prev_e    = lcd_e;
            prev_word = {lcd_rs, lcd_data};
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic offer(input logic [7:0] code, input logic line, input logic [5:0] col);
        @(negedge clk);
        in_valid = 1'b1;
        in_code  = code;
        in_line  = line;
        in_col   = col;
        while (!in_ready) @(negedge clk);
        @(posedge clk);          // taken at this edge
        @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!in_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_char(input int start, input int code, input int line, input int col,
                              input string tag);
        logic [8:0] pos;
        pos = {1'b0, 8'h80 | 8'(line << 6) | 8'(col)};
        check(cap[start] == pos, {"R4 position command ", tag}, cap[start], pos);
        for (int i = 0; i < 8; i++) begin
            check(cap[start + 1 + i] == glyph_word(code, i), {"R5 glyph byte ", tag},
                  cap[start + 1 + i], glyph_word(code, i));
        end
    endtask

    task automatic check_init(input int start, input string tag);
        logic [8:0] exp_w [4];
        exp_w = '{9'h038, 9'h00C, 9'h006, 9'h001};
        for (int i = 0; i < 4; i++) begin
            check(cap[start + i] == exp_w[i], {"R1 setup command ", tag}, cap[start + i], exp_w[i]);
        end
    endtask

    // stimulus table: {code, line, col}
    localparam int NVEC = 5;
    localparam logic [14:0] VEC [NVEC] = '{
        {8'h41, 1'b0, 6'd0},
        {8'h00, 1'b1, 6'd5},   // R9 low end of glyph memory
        {8'hFF, 1'b1, 6'd39},  // R9 high end of glyph memory
        {8'h7E, 1'b0, 6'd17},
        {8'h80, 1'b1, 6'd63}
    };

    initial begin
        int n;
        int start;
        // ---- reset state ----
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(in_ready == 1'b0, "R1 ready low in reset", in_ready, 0);
        check(lcd_e == 1'b0, "R1 E low in reset", lcd_e, 0);
        check(lcd_rw == 1'b0, "R8 RW low in reset", lcd_rw, 0);
        start = wr_cnt;
        rst_n = 1'b1;
        count_busy(n);
        check(n == 320, "R1 ready delay after reset", n, 320);
        check(wr_cnt - start == 4, "R1 setup write count", wr_cnt - start, 4);
        check_init(start, "after power-up");

        // ---- table walk ----
        for (int v = 0; v < NVEC; v++) begin
            start = wr_cnt;
            offer(VEC[v][14:7], VEC[v][6], VEC[v][5:0]);
            in_valid = 1'b0;
            count_busy(n);
            check(n == 720, "R2 busy length", n, 720);
            check(wr_cnt - start == 9, "R6 one write per pulse", wr_cnt - start, 9);
            check_char(start, int'(VEC[v][14:7]), int'(VEC[v][6]), int'(VEC[v][5:0]), "table");
            // R11: stays quiet while idle
            repeat (200) @(negedge clk);
            check(wr_cnt - start == 9, "R11 no pulse while idle", wr_cnt - start, 9);
            check(in_ready == 1'b1, "R2 ready while idle", in_ready, 1);
        end

        // ---- R3: request held while busy ----
        start = wr_cnt;
        offer(8'h33, 1'b0, 6'd2);
        in_code = 8'hC5;
        in_line = 1'b1;
        in_col  = 6'd9;
        check(in_ready == 1'b0, "R2 ready low while busy", in_ready, 0);
        count_busy(n);
        check(n == 720, "R3 first char unaffected by waiting request", n, 720);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        count_busy(n);
        check(n == 720, "R3 waiting request taken", n, 720);
        check(wr_cnt - start == 18, "R3 writes for both chars", wr_cnt - start, 18);
        check_char(start, 8'h33, 0, 2, "R3 first");
        check_char(start + 9, 8'hC5, 1, 9, "R3 second");

        // ---- R10: reset in the middle of a character ----
        offer(8'h12, 1'b0, 6'd1);
        in_valid = 1'b0;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(lcd_e == 1'b0, "R10 E low on reset", lcd_e, 0);
        check(in_ready == 1'b0, "R10 ready low on reset", in_ready, 0);
        @(negedge clk);
        start = wr_cnt;
        rst_n = 1'b1;
        count_busy(n);
        check(n == 320, "R10 setup rerun length", n, 320);
        check(wr_cnt - start == 4, "R10 setup rerun writes", wr_cnt - start, 4);
        check_init(start, "R10 after mid reset");

        check(rw_bad == 0, "R8 RW stayed low", rw_bad, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule